// File: doc/BRIEF.md
# Cache Line Write-Policy State Logic

This block decides how a data cache line is held after an access. It has two parts. The first part works out the page-level writethrough bit. It takes that bit from one of three candidate sources, chosen by the operating mode, the paging-enable bit and the kind of memory access. The second part combines that bit with an external per-cycle policy pin. The result sets the coherence state (invalid, shared, exclusive, modified) of a line in a small, directly indexed state array.

On every clock the block accepts one access event for the indexed line. The event is a read miss, a write hit or a write miss. The block also shows the current state of the indexed line and the selected writethrough bit, both without delay, so the surrounding cache control can act in the same cycle. A debug-mode flag changes how fills are treated. Tag comparison, data storage, snooping and bus sequencing belong to other blocks.

Top module: `wpol_line_state`

## Requirements
- R1: `wtOut` is 0 when `opMode` is real (0) or reserved (3), and also when `pagingOn` is 0, whatever the other inputs are. Protected is 1 and virtual-8086 is 2.
- R2: When paging is on in protected or virtual-8086 mode, an access of class 0 or class 3 makes `wtOut` equal `wtBase`. Class 0 covers I/O space, directory entries and other non-paged accesses; class 3 is reserved.
- R3: When paging is on in protected or virtual-8086 mode, an access of class 1 makes `wtOut` equal `wtDir`. Class 1 covers small-page table entries and large pages.
- R4: When paging is on in protected or virtual-8086 mode, an access of class 2 makes `wtOut` equal `wtTable`. Class 2 covers small pages.
- R5: A read miss (`accEvent`=1) outside debug mode fills the line as exclusive (2'b10) when `wtOut`=0 and `policyPin`=1. In every other case it fills the line as shared (2'b01). The new state shows on `lineState` after the next rising edge.
- R6: A write hit (`accEvent`=2) to a shared line moves it to exclusive when `wtOut`=0 and `policyPin`=1. Otherwise the line stays shared.
- R7: A write hit to an exclusive line makes it modified (2'b11). A write hit to a modified line keeps it modified.
- R8: In debug mode, a read miss leaves the line state unchanged.
- R9: A write miss (`accEvent`=3) leaves the line unchanged, with one exception: in debug mode, a shared line moves to exclusive when `wtOut`=0 and `policyPin`=1.
- R10: An invalid line (2'b00) stays invalid for every event except a read miss outside debug mode. `accEvent`=0 changes no line.
- R11: After reset, every line reads invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opMode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 reserved |
| pagingOn | input | 1 | Paging-enable control bit |
| wtBase | input | 1 | Writethrough bit from the page-directory base register |
| wtDir | input | 1 | Writethrough bit from the page directory entry |
| wtTable | input | 1 | Writethrough bit from the page table entry |
| accClass | input | 2 | 0 non-paged, 1 table entry or large page, 2 small page, 3 reserved |
| policyPin | input | 1 | External writeback (1) / writethrough (0) input |
| dbgMode | input | 1 | Debug-mode flag |
| lineIdx | input | IdxW | Index of the accessed line |
| accEvent | input | 2 | 0 none, 1 read miss, 2 write hit, 3 write miss |
| wtOut | output | 1 | Selected writethrough bit, combinational |
| lineState | output | 2 | Current state of the indexed line |

## Verification
The state properties follow a line across one edge. They therefore assume that the same index is presented again on the next cycle, and they apply only when that holds. The properties also assume that only the addressed line can change on a given cycle. The stimulus drives a fixed-seed random mix of modes, classes, pins, debug flags and events over the whole index range, so repeats of the same index occur often enough to engage these properties. Directed sequences on chosen lines force each transition: fills, promotion to modified, and the debug-mode write-miss path. The bench tracks every line in its own model.

// File: rtl/wpol_pkg.sv
package wpol_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_t;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_RD_MISS = 2'd1,
    EV_WR_HIT  = 2'd2,
    EV_WR_MISS = 2'd3
  } accEvent_t;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_RSVD = 2'd3
  } opMode_t;

  typedef enum logic [1:0] {
    CLS_UNPAGED = 2'd0,
    CLS_DIRLVL  = 2'd1,
    CLS_PAGE4K  = 2'd2,
    CLS_OTHER   = 2'd3
  } accClass_t;

  // Strobes from control to the state array
  typedef struct packed {
    logic       wrEn;
    lineState_t wrState;
  } stateStrobe_t;

endpackage

// File: rtl/wpol_policy_ctrl.sv
module wpol_policy_ctrl
  import wpol_pkg::*;
(
  input  opMode_t      opMode,
  input  logic         pagingOn,
  input  logic         wtBase,
  input  logic         wtDir,
  input  logic         wtTable,
  input  accClass_t    accClass,
  input  logic         policyPin,
  input  logic         dbgMode,
  input  accEvent_t    accEvent,
  input  lineState_t   curState,
  output logic         wtOut,
  output stateStrobe_t strobe
);

  logic pagedMode;
  logic exclOk;

  // Writethrough source selection
  always_comb begin
    pagedMode = (opMode == MODE_PROT) || (opMode == MODE_V86);
    wtOut = 1'b0;
    if (pagedMode && pagingOn) begin
      unique case (accClass)
        CLS_DIRLVL: wtOut = wtDir;
        CLS_PAGE4K: wtOut = wtTable;
        default:    wtOut = wtBase;
      endcase
    end
  end

  assign exclOk = !wtOut && policyPin;

  // Line state transition
  always_comb begin
    strobe.wrEn    = 1'b0;
    strobe.wrState = curState;
    unique case (accEvent)
      EV_RD_MISS: begin
        if (!dbgMode) begin
          strobe.wrEn    = 1'b1;
          strobe.wrState = exclOk ? LS_EXC : LS_SHR;
        end
      end
      EV_WR_HIT: begin
        unique case (curState)
          LS_SHR: begin
            strobe.wrEn    = 1'b1;
            strobe.wrState = exclOk ? LS_EXC : LS_SHR;
          end
          LS_EXC, LS_MOD: begin
            strobe.wrEn    = 1'b1;
            strobe.wrState = LS_MOD;
          end
          default: ;
        endcase
      end
      EV_WR_MISS: begin
        if (dbgMode && exclOk && (curState == LS_SHR)) begin
          strobe.wrEn    = 1'b1;
          strobe.wrState = LS_EXC;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wpol_state_array.sv
module wpol_state_array
  import wpol_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IdxW = $clog2(LINES)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [IdxW-1:0] lineIdx,
  input  stateStrobe_t strobe,
  output lineState_t   curState
);

  lineState_t states [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        states[g] <= LS_INV;
      end else if (strobe.wrEn && (lineIdx == IdxW'(g))) begin
        states[g] <= strobe.wrState;
      end
    end
  end

  assign curState = states[lineIdx];

endmodule

// File: rtl/wpol_line_state.sv
module wpol_line_state
  import wpol_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IdxW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      opMode,
  input  logic            pagingOn,
  input  logic            wtBase,
  input  logic            wtDir,
  input  logic            wtTable,
  input  logic [1:0]      accClass,
  input  logic            policyPin,
  input  logic            dbgMode,
  input  logic [IdxW-1:0] lineIdx,
  input  logic [1:0]      accEvent,
  output logic            wtOut,
  output logic [1:0]      lineState
);

  stateStrobe_t strobe;
  lineState_t   curState;

  wpol_policy_ctrl u_ctrl (
    .opMode    (opMode_t'(opMode)),
    .pagingOn  (pagingOn),
    .wtBase    (wtBase),
    .wtDir     (wtDir),
    .wtTable   (wtTable),
    .accClass  (accClass_t'(accClass)),
    .policyPin (policyPin),
    .dbgMode   (dbgMode),
    .accEvent  (accEvent_t'(accEvent)),
    .curState  (curState),
    .wtOut     (wtOut),
    .strobe    (strobe)
  );

  wpol_state_array #(.LINES(LINES)) u_array (
    .clk      (clk),
    .rstN     (rstN),
    .lineIdx  (lineIdx),
    .strobe   (strobe),
    .curState (curState)
  );

  assign lineState = curState;

endmodule

// File: rtl/wpol_line_state_chk.sv
module wpol_line_state_chk #(
  parameter int LINES = 16,
  localparam int IdxW = $clog2(LINES)
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      opMode,
  input logic            pagingOn,
  input logic            wtBase,
  input logic            wtDir,
  input logic            wtTable,
  input logic [1:0]      accClass,
  input logic            policyPin,
  input logic            dbgMode,
  input logic [IdxW-1:0] lineIdx,
  input logic [1:0]      accEvent,
  input logic            wtOut,
  input logic [1:0]      lineState
);

  logic paged;
  assign paged = ((opMode == 2'd1) || (opMode == 2'd2)) && pagingOn;

  // R1
  wt_forced_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !paged |-> !wtOut);

  // R2
  wt_base_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paged && (accClass == 2'd0 || accClass == 2'd3)) |-> (wtOut == wtBase));

  // R3
  wt_dir_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paged && accClass == 2'd1) |-> (wtOut == wtDir));

  // R4
  wt_table_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paged && accClass == 2'd2) |-> (wtOut == wtTable));

  // R5
  read_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEvent == 2'd1 && !dbgMode) ##1 (lineIdx == $past(lineIdx)) |->
      (lineState == ($past(!wtOut && policyPin) ? 2'b10 : 2'b01)));

  // R7
  promote_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEvent == 2'd2 && lineState[1]) ##1 (lineIdx == $past(lineIdx)) |->
      (lineState == 2'b11));

  // R8
  dbg_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEvent == 2'd1 && dbgMode) ##1 (lineIdx == $past(lineIdx)) |->
      (lineState == $past(lineState)));

  // R10
  inv_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == 2'b00 && !(accEvent == 2'd1 && !dbgMode)) ##1
      (lineIdx == $past(lineIdx)) |-> (lineState == 2'b00));

endmodule

bind wpol_line_state wpol_line_state_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opMode    (opMode),
  .pagingOn  (pagingOn),
  .wtBase    (wtBase),
  .wtDir     (wtDir),
  .wtTable   (wtTable),
  .accClass  (accClass),
  .policyPin (policyPin),
  .dbgMode   (dbgMode),
  .lineIdx   (lineIdx),
  .accEvent  (accEvent),
  .wtOut     (wtOut),
  .lineState (lineState)
);

// File: tb/tb_wpol_line_state.sv
module tb_wpol_line_state;

  localparam int LINES = 16;
  localparam int IdxW = $clog2(LINES);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      opMode = '0;
  logic            pagingOn = 1'b0;
  logic            wtBase = 1'b0;
  logic            wtDir = 1'b0;
  logic            wtTable = 1'b0;
  logic [1:0]      accClass = '0;
  logic            policyPin = 1'b0;
  logic            dbgMode = 1'b0;
  logic [IdxW-1:0] lineIdx = '0;
  logic [1:0]      accEvent = '0;
  logic            wtOut;
  logic [1:0]      lineState;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] model [LINES];
  string      lastTag [LINES];

  wpol_line_state #(.LINES(LINES)) dut (
    .clk(clk), .rstN(rstN), .opMode(opMode), .pagingOn(pagingOn),
    .wtBase(wtBase), .wtDir(wtDir), .wtTable(wtTable), .accClass(accClass),
    .policyPin(policyPin), .dbgMode(dbgMode), .lineIdx(lineIdx),
    .accEvent(accEvent), .wtOut(wtOut), .lineState(lineState)
  );

  always #5 clk = ~clk;

  function automatic logic expWt(logic [1:0] m, logic pg, logic b, logic d,
                                 logic t, logic [1:0] c);
    if (!((m == 2'd1 || m == 2'd2) && pg)) return 1'b0;
    case (c)
      2'd1:    return d;
      2'd2:    return t;
      default: return b;
    endcase
  endfunction

  function automatic string wtTag(logic [1:0] m, logic pg, logic [1:0] c);
    if (!((m == 2'd1 || m == 2'd2) && pg)) return "R1";
    if (c == 2'd1) return "R3";
    if (c == 2'd2) return "R4";
    return "R2";
  endfunction

  task automatic nextState(input logic [1:0] cur, input logic [1:0] ev,
                           input logic excl, input logic dbg,
                           output logic [1:0] nxt, inout string tag);
    nxt = cur;
    case (ev)
      2'd1: if (dbg) tag = "R8";
            else begin nxt = excl ? 2'b10 : 2'b01; tag = "R5"; end
      2'd2: case (cur)
              2'b00: tag = "R10";
              2'b01: begin nxt = excl ? 2'b10 : 2'b01; tag = "R6"; end
              default: begin nxt = 2'b11; tag = "R7"; end
            endcase
      2'd3: begin
              if (cur == 2'b00) tag = "R10";
              else tag = "R9";
              if (dbg && excl && cur == 2'b01) nxt = 2'b10;
            end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic pg, input logic b,
                      input logic d, input logic t, input logic [1:0] c,
                      input logic pin, input logic dbg,
                      input logic [IdxW-1:0] idx, input logic [1:0] ev);
    logic ew;
    logic [1:0] nxt;
    string tg;
    @(negedge clk);
    opMode = m; pagingOn = pg; wtBase = b; wtDir = d; wtTable = t;
    accClass = c; policyPin = pin; dbgMode = dbg; lineIdx = idx; accEvent = ev;
    #2;
    ew = expWt(m, pg, b, d, t, c);
    check(wtTag(m, pg, c), {1'b0, wtOut}, {1'b0, ew});
    check(lastTag[idx], lineState, model[idx]);
    tg = lastTag[idx];
    nextState(model[idx], ev, !ew && pin, dbg, nxt, tg);
    model[idx] = nxt;
    lastTag[idx] = tg;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < LINES; i++) begin
      model[i] = 2'b00;
      lastTag[i] = "R11";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: all lines invalid after reset
    for (int i = 0; i < LINES; i++)
      step(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, IdxW'(i), 2'd0);
    // R5 exclusive fill, R7 promote and hold, R8 debug read miss
    step(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, IdxW'(3), 2'd1);
    step(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, IdxW'(3), 2'd2);
    step(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, IdxW'(3), 2'd2);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, IdxW'(3), 2'd1);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, IdxW'(3), 2'd0);
    // R5 shared fill with R3 writethrough high, R6 stays shared then exclusive
    step(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, IdxW'(4), 2'd1);
    step(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, IdxW'(4), 2'd2);
    step(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, IdxW'(4), 2'd2);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, IdxW'(4), 2'd0);
    // R9 write miss: normal hold, then debug shared to exclusive
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, IdxW'(5), 2'd1);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, IdxW'(5), 2'd3);
    step(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, IdxW'(5), 2'd3);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, IdxW'(5), 2'd0);
    // R10 write hit and debug write miss on an invalid line
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, IdxW'(7), 2'd2);
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, IdxW'(7), 2'd3);
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, IdxW'(7), 2'd0);
    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 3) != 0),
           1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom_range(0, 3)), 1'($urandom),
           ($urandom_range(0, 4) == 0),
           IdxW'($urandom_range(0, (n % 3 == 0) ? 3 : LINES - 1)),
           2'($urandom_range(0, 3)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule